// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two external-memory strobes of an 8-bit microcontroller. The address-latch strobe is active high and the program-fetch read strobe is active low. It runs on the oscillator clock. It divides that clock into machine cycles of twelve clocks, made of six states of two phases each, and it reports the current state and phase to the rest of the core.

For each machine cycle, the core supplies three control inputs: whether code is fetched from external program memory, whether the cycle moves data to or from external data memory, and whether the cycle reads a code table. The block samples these inputs once, on the last clock of the preceding cycle, and uses them to shape both strobes for the whole cycle. Normally the latch strobe pulses twice per cycle, one sixth of the oscillator rate. The fetch strobe pulses twice per cycle when code comes from outside. A data-access cycle drops one latch pulse and both fetch pulses.

A configuration register location holds a latch-strobe disable bit. While internal code executes, that bit stops the latch strobe in every cycle that is neither a data move nor a code-table read. In such a cycle the driver is released and the line rests at its pulled-up high level. During external execution the bit has no effect.

Top module: `bus_strobe_gen`

## Requirements
- R1: A machine cycle lasts 12 clocks. `state_num` steps 0,1,2,3,4,5, and each state lasts two clocks: `phase` is 0 on the first clock of a state and 1 on the second.
- R2: In an enabled cycle that is not a data access, `ale` is 1 for the whole of state 0 and the whole of state 3, and 0 for the rest of the cycle. This gives two pulses per cycle.
- R3: In an enabled data-access cycle (`movx_cycle` sampled as 1), the state-3 pulse of `ale` is omitted and the state-0 pulse is kept.
- R4: When `ext_exec` is sampled as 1, `psen_n` is 0 throughout states 1 and 4 and 1 elsewhere. In a data-access cycle both of these assertions are omitted, and `psen_n` stays 1 for the whole cycle.
- R5: When `ext_exec` is sampled as 0, `psen_n` stays 1 for the whole cycle.
- R6: A write with `cfg_addr` = 8'h8E loads bit 0 of `cfg_wdata` as the disable bit. Take a cycle that starts with this bit at 1, with `ext_exec` at 0 and with neither `movx_cycle` nor `movc_cycle` at 1. In that cycle `ale_oe` is 0 and `ale` is 1 on all 12 clocks. Clearing the bit restores the pulses of R2 from the next cycle.
- R7: While the disable bit is set, a cycle with `movc_cycle` at 1 has the pulses of R2, and a cycle with `movx_cycle` at 1 has the pulses of R3. In both cases `ale_oe` is 1.
- R8: When `ext_exec` is sampled as 1, the disable bit has no effect: `ale_oe` is 1 and `ale` follows R2 or R3.
- R9: A write to any other address leaves the disable bit unchanged, and reset clears the disable bit.
- R10: `ext_exec`, `movx_cycle`, `movc_cycle` and the disable bit are sampled only on the clock that ends state 5 phase 1. A change at any other time has no effect on the cycle in progress.
- R11: While reset is asserted, the outputs are `ale`=0, `ale_oe`=1, `psen_n`=1, `state_num`=5 and `phase`=1. The first clock after the internal reset releases starts state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_exec | input | 1 | Code is fetched from external program memory |
| movx_cycle | input | 1 | The coming machine cycle accesses external data memory |
| movc_cycle | input | 1 | The coming machine cycle reads a code table |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| ale | output | 1 | Address-latch strobe, active high |
| ale_oe | output | 1 | Driver enable for the address-latch strobe; 0 means the line rests at its pull-up level |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| state_num | output | 3 | Current state within the machine cycle, 0 to 5 |
| phase | output | 1 | Current phase within the state |

## Verification
The properties assume that the cycle controls change only on a machine-cycle boundary. They also assume that a configuration write completes before the boundary at which it is meant to take effect. The bench drives the controls on the falling edge that precedes the boundary clock, and it issues configuration writes early in a cycle. In every cycle it also inverts the controls part-way through, to show that such changes are ignored, and it checks every clock of every cycle against a model of the state-by-state strobe pattern.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Attributes frozen for one machine cycle
  typedef struct packed {
    logic ext;   // fetch from external program memory
    logic movx;  // external data access in this cycle
    logic movc;  // code-table read in this cycle
    logic en;    // latch strobe driven in this cycle
  } cyc_attr_t;

  localparam cyc_attr_t ATTR_RST = '{ext: 1'b0, movx: 1'b0, movc: 1'b0, en: 1'b1};

endpackage

// File: rtl/bus_strobe_rst_sync.sv
module bus_strobe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bus_strobe_timer.sv
module bus_strobe_timer #(
  parameter int STATES = 6,
  parameter int ST_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ST_W-1:0] st_q,
  output logic            ph_q,
  output logic [ST_W-1:0] st_nxt,
  output logic            ph_nxt,
  output logic            wrap
);

  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);

  always_comb begin
    wrap   = (st_q == ST_LAST) && ph_q;
    ph_nxt = ~ph_q;
    st_nxt = st_q;
    if (ph_q) begin
      if (st_q == ST_LAST) st_nxt = '0;
      else                 st_nxt = st_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_LAST;
      ph_q <= 1'b1;
    end else begin
      st_q <= st_nxt;
      ph_q <= ph_nxt;
    end
  end

endmodule

// File: rtl/bus_strobe_cycle_ctl.sv
module bus_strobe_cycle_ctl
  import bus_strobe_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR = 8'h8E,
  parameter int         DIS_BIT  = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrap,
  input  logic      ext_exec,
  input  logic      movx_cycle,
  input  logic      movc_cycle,
  input  logic      cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output cyc_attr_t attr_q,
  output cyc_attr_t attr_nxt,
  output logic      dis_q
);

  logic dis_we;
  logic dis_nxt;

  always_comb begin
    dis_we  = cfg_we && (cfg_addr == CFG_ADDR);
    dis_nxt = dis_we ? cfg_wdata[DIS_BIT] : dis_q;
  end

  always_comb begin
    attr_nxt = attr_q;
    if (wrap) begin
      attr_nxt.ext  = ext_exec;
      attr_nxt.movx = movx_cycle;
      attr_nxt.movc = movc_cycle;
      attr_nxt.en   = ext_exec | movx_cycle | movc_cycle | ~dis_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      attr_q <= ATTR_RST;
    end else begin
      if (dis_we) dis_q  <= dis_nxt;
      if (wrap)   attr_q <= attr_nxt;
    end
  end

endmodule

// File: rtl/bus_strobe_outputs.sv
module bus_strobe_outputs
  import bus_strobe_pkg::*;
#(
  parameter int                STATES    = 6,
  parameter int                ST_W      = 3,
  parameter logic [STATES-1:0] ALE_MASK  = 6'b001001,
  parameter logic [STATES-1:0] ALE_SKIP  = 6'b001000,
  parameter logic [STATES-1:0] PSEN_MASK = 6'b010010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_nxt,
  input  cyc_attr_t       attr_nxt,
  output logic            ale_q,
  output logic            ale_oe_q,
  output logic            psen_n_q
);

  logic [STATES-1:0] ale_hit;
  logic [STATES-1:0] psen_hit;
  logic ale_d, ale_oe_d, psen_n_d;

  for (genvar s = 0; s < STATES; s++) begin : g_dec
    assign ale_hit[s]  = (st_nxt == ST_W'(s)) && ALE_MASK[s]
                         && !(attr_nxt.movx && ALE_SKIP[s]);
    assign psen_hit[s] = (st_nxt == ST_W'(s)) && PSEN_MASK[s];
  end

  always_comb begin
    ale_oe_d = attr_nxt.en;
    ale_d    = attr_nxt.en ? |ale_hit : 1'b1;
    psen_n_d = !(attr_nxt.ext && !attr_nxt.movx && |psen_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      ale_oe_q <= 1'b1;
      psen_n_q <= 1'b1;
    end else begin
      ale_q    <= ale_d;
      ale_oe_q <= ale_oe_d;
      psen_n_q <= psen_n_d;
    end
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int                STATES    = 6,
  parameter int                SYNC_STG  = 2,
  parameter logic [7:0]        CFG_ADDR  = 8'h8E,
  parameter int                DIS_BIT   = 0,
  parameter logic [STATES-1:0] ALE_MASK  = 6'b001001,
  parameter logic [STATES-1:0] ALE_SKIP  = 6'b001000,
  parameter logic [STATES-1:0] PSEN_MASK = 6'b010010,
  localparam int               ST_W      = $clog2(STATES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_exec,
  input  logic            movx_cycle,
  input  logic            movc_cycle,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic            ale,
  output logic            ale_oe,
  output logic            psen_n,
  output logic [ST_W-1:0] state_num,
  output logic            phase
);

  logic            rst_core_n;
  logic [ST_W-1:0] st_nxt;
  logic            ph_nxt;
  logic            wrap;
  logic            dis_q;
  cyc_attr_t       attr_q;
  cyc_attr_t       attr_nxt;

  bus_strobe_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  bus_strobe_timer #(.STATES(STATES), .ST_W(ST_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .st_q   (state_num),
    .ph_q   (phase),
    .st_nxt (st_nxt),
    .ph_nxt (ph_nxt),
    .wrap   (wrap)
  );

  bus_strobe_cycle_ctl #(.CFG_ADDR(CFG_ADDR), .DIS_BIT(DIS_BIT)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wrap       (wrap),
    .ext_exec   (ext_exec),
    .movx_cycle (movx_cycle),
    .movc_cycle (movc_cycle),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .attr_q     (attr_q),
    .attr_nxt   (attr_nxt),
    .dis_q      (dis_q)
  );

  bus_strobe_outputs #(
    .STATES(STATES), .ST_W(ST_W),
    .ALE_MASK(ALE_MASK), .ALE_SKIP(ALE_SKIP), .PSEN_MASK(PSEN_MASK)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .st_nxt   (st_nxt),
    .attr_nxt (attr_nxt),
    .ale_q    (ale),
    .ale_oe_q (ale_oe),
    .psen_n_q (psen_n)
  );

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int ST_W    = 3,
  parameter int ST_LAST = 5,
  parameter int SKIP_ST = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] state_num,
  input logic            phase,
  input logic            ale,
  input logic            ale_oe,
  input logic            psen_n,
  input logic            cyc_ext,
  input logic            cyc_movx,
  input logic            cyc_en
);

  assert_state_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_num == ST_W'(ST_LAST) && phase) |=> (state_num == '0 && !phase));

  assert_phase_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase)));

  assert_ale_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (!phase && (state_num == '0 || state_num == ST_W'(SKIP_ST))));

  assert_movx_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_movx && cyc_en && state_num == ST_W'(SKIP_ST)) |-> !ale);

  assert_psen_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_movx |-> psen_n);

  assert_psen_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_ext |-> psen_n);

  assert_released_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_oe |-> ale);

  assert_ext_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ext |-> ale_oe);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && ale_oe && !psen_n));

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.ST_W(ST_W), .ST_LAST(STATES - 1), .SKIP_ST(3)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .state_num (state_num),
  .phase     (phase),
  .ale       (ale),
  .ale_oe    (ale_oe),
  .psen_n    (psen_n),
  .cyc_ext   (attr_q.ext),
  .cyc_movx  (attr_q.movx),
  .cyc_en    (attr_q.en)
);

// File: tb/bus_strobe_gen_test.sv
module bus_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_exec = 1'b0, movx_cycle = 1'b0, movc_cycle = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic       ale, ale_oe, psen_n, phase;
  logic [2:0] state_num;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  model_dis = 1'b0;

  always #2 clk = ~clk;

  bus_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .movx_cycle(movx_cycle),
    .movc_cycle(movc_cycle), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n),
    .state_num(state_num), .phase(phase)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (!(state_num == 3'd5 && phase == 1'b1)) @(negedge clk);
  endtask

  // Caller is at the negedge before the boundary clock; leaves at the next one.
  task automatic run_cycle(input bit ext, input bit mx, input bit mc,
                           input string ale_tag, input string psen_tag,
                           input bit do_wr, input logic [7:0] wa, input logic [7:0] wd);
    bit en;
    en = ext || !model_dis || mx || mc;
    ext_exec = ext; movx_cycle = mx; movc_cycle = mc;
    for (int i = 0; i < 12; i++) begin
      int st;
      bit ale_e, psen_e;
      @(negedge clk);
      st = i / 2;
      ale_e  = en ? ((st == 0) || (st == 3 && !mx)) : 1'b1;
      psen_e = !(ext && !mx && (st == 1 || st == 4));
      check("R1", "state_num", int'(state_num), st);
      check("R1", "phase", int'(phase), i % 2);
      check(ale_tag, "ale", int'(ale), int'(ale_e));
      check(ale_tag, "ale_oe", int'(ale_oe), int'(en));
      check(psen_tag, "psen_n", int'(psen_n), int'(psen_e));
      if (i == 0 && do_wr) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
      if (i == 1) cfg_we = 1'b0;
      if (i == 3) begin  // R10: mid-cycle changes must be ignored
        ext_exec = ~ext; movx_cycle = ~mx; movc_cycle = ~mc;
      end
    end
    if (do_wr && wa == 8'h8E) model_dis = wd[0];
  endtask

  task automatic t_reset();
    #1;
    check("R11", "ale", int'(ale), 0);
    check("R11", "ale_oe", int'(ale_oe), 1);
    check("R11", "psen_n", int'(psen_n), 1);
    check("R11", "state_num", int'(state_num), 5);
    check("R11", "phase", int'(phase), 1);
    model_dis = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    align();
  endtask

  task automatic t_internal();
    run_cycle(0, 0, 0, "R2", "R5", 0, 8'h00, 8'h00);
    run_cycle(0, 1, 0, "R3", "R5", 0, 8'h00, 8'h00);
  endtask

  task automatic t_external();
    run_cycle(1, 0, 0, "R2", "R4", 0, 8'h00, 8'h00);
    run_cycle(1, 1, 0, "R3", "R4", 0, 8'h00, 8'h00);
    run_cycle(1, 0, 1, "R2", "R4", 0, 8'h00, 8'h00);
  endtask

  task automatic t_sampling();
    run_cycle(0, 0, 0, "R10", "R10", 0, 8'h00, 8'h00);
    run_cycle(1, 1, 0, "R10", "R10", 0, 8'h00, 8'h00);
  endtask

  task automatic t_disable();
    run_cycle(0, 0, 0, "R9", "R5", 1, 8'h8F, 8'hFF);   // other address
    run_cycle(0, 0, 0, "R9", "R5", 1, 8'h8E, 8'h01);   // set disable bit
    run_cycle(0, 0, 0, "R6", "R5", 0, 8'h00, 8'h00);
    run_cycle(0, 0, 1, "R7", "R5", 0, 8'h00, 8'h00);
    run_cycle(0, 1, 0, "R7", "R5", 0, 8'h00, 8'h00);
    run_cycle(1, 0, 0, "R8", "R4", 0, 8'h00, 8'h00);
    run_cycle(1, 1, 0, "R8", "R4", 0, 8'h00, 8'h00);
    run_cycle(0, 0, 0, "R6", "R5", 1, 8'h8E, 8'h00);   // clear
    run_cycle(0, 0, 0, "R6", "R5", 0, 8'h00, 8'h00);
  endtask

  task automatic t_reset_clears();
    run_cycle(0, 0, 0, "R6", "R5", 1, 8'h8E, 8'h01);
    run_cycle(0, 0, 0, "R6", "R5", 0, 8'h00, 8'h00);
    rst_n = 1'b0;
    t_reset();
    release_reset();
    run_cycle(0, 0, 0, "R9", "R5", 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    release_reset();
    t_internal();
    t_external();
    t_sampling();
    t_disable();
    t_reset_clears();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule